// File: doc/BRIEF.md
# Software-Loaded TLB Entry Writer

This block is a small fully associative address translation buffer whose entries are built by software one register write at a time. Software first stages a page descriptor: an effective page number, an address space tag and an entry-valid flag go into one staging register, and a protection group, a guarded flag, a page-size code and a segment-valid flag go into a second. A write to the real-page register is the commit event. It merges both staged registers with the real page number being written and stores the whole entry in one step, at the slot named by the control register.

A combinational lookup port takes an effective address. It reports whether any valid entry matches that address under the current address space, which a separate register holds. On a hit it returns the translated real address, the entry's attributes and the index of the matching slot. Each entry carries its own page size, so entries covering 4 KB, 16 KB, 512 KB and 8 MB pages can be resident together. Handling of a miss is left to software.

Top module: `tlb_entry_writer`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses. The control register starts at 0x04000000, which means the load index is 0 and the reserve bit is clear.
- R2: Register writes use `wrSel`: 0 is control, 1 is the effective page stage, 2 is the segment attribute stage, 3 is the real page commit and 4 is the current address space. Writes with codes 5 to 7 are ignored. Writes to the two staging registers leave every stored entry unchanged.
- R3: A write with code 3 stores a new entry at the slot held in control bits 12:8, and a lookup in the following cycle sees it. The real page number is taken from bits 31:12 of the written word.
- R4: The effective page stage holds the page number in bits 31:12, the entry-valid flag at bit 9 and the 4-bit tag in bits 3:0. The stored entry is valid only when both entry-valid and segment-valid (bit 0 of the segment stage) were set.
- R5: A lookup hits only on a valid entry whose tag equals bits 3:0 of the last value written with code 4.
- R6: Page size comes from segment stage bits 3:2. Code 11 selects 8 MB and code 01 selects 512 KB. Codes 00 and 10 select a small page, which is 16 KB when bit 3 of the committed real-page word is 1 and 4 KB when it is 0. Only the address bits above the page size take part in the compare.
- R7: On a hit, the real address takes the stored real page bits above the page size and the effective address bits below it. On a miss, the real address, group, guarded flag and slot outputs are all 0.
- R8: On a hit, the protection group (segment stage bits 8:5) and the guarded flag (bit 4) of the entry are returned.
- R9: When several entries match, the entry with the lowest index is reported.
- R10: While control bit 27 (reserve) is set, commits aimed at the top RESERVED slots are dropped and those slots keep their contents. Commits to lower slots proceed normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register select code |
| wrData | input | 32 | Register write data |
| lkEa | input | 32 | Effective address to translate |
| lkHit | output | 1 | A matching entry exists |
| lkPa | output | 32 | Translated real address |
| lkGroup | output | 4 | Protection group of the hit entry |
| lkGuarded | output | 1 | Guarded flag of the hit entry |
| lkSlot | output | 5 | Index of the hit entry |

## Verification
The bench builds the block with 32 slots and 4 reserved slots, which is the default. With 32 slots, every value of the 5-bit index field names a real slot. With 4 reserved slots, the reserved window is slots 28 to 31, so the bench can aim commits both just below it and inside it. The bench loads all four page sizes, including the case where size code 10 falls back to a small page. It also creates overlapping matches at two indices and switches the current address space between hits and misses. A pseudo-random phase then mixes writes and lookups, and a behavioural model checks every cycle.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
  localparam int WORD_W  = 32;
  localparam int PAGE_LSB = 12;
  localparam int VPN_W   = WORD_W - PAGE_LSB;
  localparam int ASID_W  = 4;
  localparam int GROUP_W = 4;
  localparam int SLOT_W  = 5;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_EPN  = 3'd1;
  localparam logic [2:0] SEL_SEG  = 3'd2;
  localparam logic [2:0] SEL_RPN  = 3'd3;
  localparam logic [2:0] SEL_ASID = 3'd4;

  localparam int CTRL_RSV_BIT = 27;
  localparam int CTRL_IDX_LSB = 8;
  localparam int EPN_VALID_BIT = 9;
  localparam int SEG_GRP_LSB = 5;
  localparam int SEG_GUARD_BIT = 4;
  localparam int SEG_PS_LSB = 2;
  localparam int SEG_VALID_BIT = 0;
  localparam int RPN_SMALL16_BIT = 3;

  typedef enum logic [1:0] {
    PG4K   = 2'd0,
    PG16K  = 2'd1,
    PG512K = 2'd2,
    PG8M   = 2'd3
  } pageSizeT;

  typedef struct packed {
    logic               valid;
    logic [VPN_W-1:0]   epn;
    logic [ASID_W-1:0]  asid;
    logic [VPN_W-1:0]   rpn;
    pageSizeT           size;
    logic [GROUP_W-1:0] group;
    logic               guarded;
  } tlbEntryT;

  typedef struct packed {
    logic              commit;
    logic [SLOT_W-1:0] slot;
    logic              reserveOn;
    tlbEntryT          entry;
  } tlbStrobeT;

  // Page-number bits that take part in a compare for each size.
  function automatic logic [VPN_W-1:0] cmpMask(pageSizeT s);
    case (s)
      PG16K:   return 20'hFFFFC;
      PG512K:  return 20'hFFF80;
      PG8M:    return 20'hFF800;
      default: return 20'hFFFFF;
    endcase
  endfunction
endpackage

// File: rtl/tlbw_ctrl.sv
module tlbw_ctrl
  import tlbw_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int RESERVED = 4,
  parameter logic [31:0] CTRL_RESET = 32'h0400_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [31:0]       wrData,
  output tlbStrobeT         strb,
  output logic [ASID_W-1:0] curAsid
);
  localparam logic [SLOT_W:0] SLOT_LIMIT = (SLOT_W+1)'(ENTRIES);
  localparam logic [SLOT_W:0] RSV_FLOOR  = (SLOT_W+1)'(ENTRIES - RESERVED);

  logic [SLOT_W-1:0]  slotQ;
  logic               rsvQ;
  logic [VPN_W-1:0]   stEpnQ;
  logic               stEValidQ;
  logic [ASID_W-1:0]  stAsidQ;
  logic [GROUP_W-1:0] stGroupQ;
  logic               stGuardQ;
  logic [1:0]         stPsQ;
  logic               stSValidQ;
  logic [ASID_W-1:0]  asidQ;

  logic unusedBits;
  assign unusedBits = ^{wrData[11:10], wrData[1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ     <= CTRL_RESET[CTRL_IDX_LSB +: SLOT_W];
      rsvQ      <= CTRL_RESET[CTRL_RSV_BIT];
      stEpnQ    <= '0;
      stEValidQ <= 1'b0;
      stAsidQ   <= '0;
      stGroupQ  <= '0;
      stGuardQ  <= 1'b0;
      stPsQ     <= '0;
      stSValidQ <= 1'b0;
      asidQ     <= '0;
    end else if (wrEn) begin
      case (wrSel)
        SEL_CTRL: begin
          slotQ <= wrData[CTRL_IDX_LSB +: SLOT_W];
          rsvQ  <= wrData[CTRL_RSV_BIT];
        end
        SEL_EPN: begin
          stEpnQ    <= wrData[WORD_W-1:PAGE_LSB];
          stEValidQ <= wrData[EPN_VALID_BIT];
          stAsidQ   <= wrData[ASID_W-1:0];
        end
        SEL_SEG: begin
          stGroupQ  <= wrData[SEG_GRP_LSB +: GROUP_W];
          stGuardQ  <= wrData[SEG_GUARD_BIT];
          stPsQ     <= wrData[SEG_PS_LSB +: 2];
          stSValidQ <= wrData[SEG_VALID_BIT];
        end
        SEL_ASID: asidQ <= wrData[ASID_W-1:0];
        default: ;
      endcase
    end
  end

  pageSizeT newSize;
  logic     slotBlocked;

  always_comb begin
    case (stPsQ)
      2'b11:   newSize = PG8M;
      2'b01:   newSize = PG512K;
      default: newSize = wrData[RPN_SMALL16_BIT] ? PG16K : PG4K;
    endcase
  end

  assign slotBlocked = ({1'b0, slotQ} >= SLOT_LIMIT) ||
                       (rsvQ && ({1'b0, slotQ} >= RSV_FLOOR));

  always_comb begin
    strb.commit        = wrEn && (wrSel == SEL_RPN) && !slotBlocked;
    strb.slot          = slotQ;
    strb.reserveOn     = rsvQ;
    strb.entry.valid   = stEValidQ && stSValidQ;
    strb.entry.epn     = stEpnQ;
    strb.entry.asid    = stAsidQ;
    strb.entry.rpn     = wrData[WORD_W-1:PAGE_LSB];
    strb.entry.size    = newSize;
    strb.entry.group   = stGroupQ;
    strb.entry.guarded = stGuardQ;
  end

  assign curAsid = asidQ;

  // R5: a space-register write is what the lookup matches against next cycle
  assert_asid_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_ASID) |=> (curAsid == $past(wrData[ASID_W-1:0])));

  // R2: writes with unused select codes change no staged state
  assert_bad_sel_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel > SEL_ASID) |=> ($stable(slotQ) && $stable(stEpnQ) &&
                                    $stable(stPsQ) && $stable(curAsid)));
endmodule

// File: rtl/tlbw_datapath.sv
module tlbw_datapath
  import tlbw_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int RESERVED = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobeT          strb,
  input  logic [ASID_W-1:0]  curAsid,
  input  logic [WORD_W-1:0]  lkEa,
  output logic               lkHit,
  output logic [WORD_W-1:0]  lkPa,
  output logic [GROUP_W-1:0] lkGroup,
  output logic               lkGuarded,
  output logic [SLOT_W-1:0]  lkSlot
);
  tlbEntryT tableQ [ENTRIES];
  logic [ENTRIES-1:0] matchVec;
  logic [VPN_W-1:0]   eaVpn;

  assign eaVpn = lkEa[WORD_W-1:PAGE_LSB];

  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) tableQ[g] <= '0;
      else if (strb.commit && strb.slot == SLOT_W'(g)) tableQ[g] <= strb.entry;
    end
    assign matchVec[g] = tableQ[g].valid && (tableQ[g].asid == curAsid) &&
                         (((tableQ[g].epn ^ eaVpn) & cmpMask(tableQ[g].size)) == '0);
  end

  logic              anyHit;
  logic [SLOT_W-1:0] hitSlot;

  always_comb begin
    anyHit  = 1'b0;
    hitSlot = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyHit  = 1'b1;
        hitSlot = SLOT_W'(i);
      end
    end
  end

  tlbEntryT         selEntry;
  logic [VPN_W-1:0] selMask;

  always_comb begin
    selEntry = tableQ[hitSlot];
    selMask  = cmpMask(selEntry.size);
    if (anyHit) begin
      lkPa      = {(selEntry.rpn & selMask) | (eaVpn & ~selMask), lkEa[PAGE_LSB-1:0]};
      lkGroup   = selEntry.group;
      lkGuarded = selEntry.guarded;
      lkSlot    = hitSlot;
    end else begin
      lkPa      = '0;
      lkGroup   = '0;
      lkGuarded = 1'b0;
      lkSlot    = '0;
    end
  end

  assign lkHit = anyHit;

  // R3: a commit leaves exactly the merged entry in its slot
  assert_commit_stored_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (tableQ[$past(strb.slot)] == $past(strb.entry)));

  // R9: no lower slot matches when a hit is reported
  assert_lowest_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> (matchVec[lkSlot] &&
               ((matchVec & ~({ENTRIES{1'b1}} << lkSlot)) == '0)));

  // R1: a miss means no slot matched at all
  assert_miss_clean_R1: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (matchVec == '0 && lkPa == '0));

  // R10: reserved slots keep their contents while the reserve bit is set
  for (genvar r = ENTRIES - RESERVED; r < ENTRIES; r++) begin : gRsvChk
    assert_reserved_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
      strb.reserveOn |=> $stable(tableQ[r]));
  end
endmodule

// File: rtl/tlb_entry_writer.sv
module tlb_entry_writer
  import tlbw_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int RESERVED = 4,
  parameter logic [31:0] CTRL_RESET = 32'h0400_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrSel,
  input  logic [31:0] wrData,
  input  logic [31:0] lkEa,
  output logic        lkHit,
  output logic [31:0] lkPa,
  output logic [3:0]  lkGroup,
  output logic        lkGuarded,
  output logic [4:0]  lkSlot
);
  tlbStrobeT         strb;
  logic [ASID_W-1:0] curAsid;

  tlbw_ctrl #(
    .ENTRIES(ENTRIES), .RESERVED(RESERVED), .CTRL_RESET(CTRL_RESET)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .strb(strb), .curAsid(curAsid)
  );

  tlbw_datapath #(
    .ENTRIES(ENTRIES), .RESERVED(RESERVED)
  ) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .curAsid(curAsid), .lkEa(lkEa),
    .lkHit(lkHit), .lkPa(lkPa), .lkGroup(lkGroup), .lkGuarded(lkGuarded),
    .lkSlot(lkSlot)
  );
endmodule

// File: tb/tb_tlb_entry_writer.sv
module tb_tlb_entry_writer;
  localparam int ENTRIES = 32;
  localparam int RESERVED = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, wrEn, lkHit, lkGuarded;
  logic [2:0]  wrSel;
  logic [31:0] wrData, lkEa, lkPa;
  logic [3:0]  lkGroup;
  logic [4:0]  lkSlot;

  tlb_entry_writer #(.ENTRIES(ENTRIES), .RESERVED(RESERVED)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .lkEa(lkEa), .lkHit(lkHit), .lkPa(lkPa), .lkGroup(lkGroup),
    .lkGuarded(lkGuarded), .lkSlot(lkSlot)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string curReq = "R1";

  bit          mValid [ENTRIES];
  logic [31:0] mEpn [ENTRIES];
  logic [31:0] mRpn [ENTRIES];
  int          mShift [ENTRIES];
  logic [3:0]  mAsid [ENTRIES];
  logic [3:0]  mGrp [ENTRIES];
  bit          mGrd [ENTRIES];
  logic [31:0] sCtrl, sEpn, sSeg;
  logic [3:0]  sAsid;
  logic [31:0] lcg = 32'h1234_5678;

  function automatic logic [31:0] nextRand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < ENTRIES; i++) mValid[i] = 0;
    sCtrl = 32'h0400_0000; sEpn = 0; sSeg = 0; sAsid = 0;
  endtask

  task automatic modelWrite(input logic [2:0] sel, input logic [31:0] d);
    int idx, sh;
    case (sel)
      3'd0: sCtrl = d;
      3'd1: sEpn = d;
      3'd2: sSeg = d;
      3'd4: sAsid = d[3:0];
      3'd3: begin
        idx = int'(sCtrl[12:8]);
        if (!(sCtrl[27] && idx >= ENTRIES - RESERVED)) begin
          if (sSeg[3:2] == 2'b11) sh = 23;
          else if (sSeg[3:2] == 2'b01) sh = 19;
          else sh = d[3] ? 14 : 12;
          mValid[idx] = sEpn[9] && sSeg[0];
          mEpn[idx] = {sEpn[31:12], 12'h0};
          mAsid[idx] = sEpn[3:0];
          mRpn[idx] = {d[31:12], 12'h0};
          mShift[idx] = sh;
          mGrp[idx] = sSeg[8:5];
          mGrd[idx] = sSeg[4];
        end
      end
      default: ;
    endcase
  endtask

  task automatic compareNow();
    bit eHit; int eSlot; logic [31:0] ePa, low; logic [3:0] eGrp; bit eGrd;
    eHit = 0; eSlot = 0; ePa = 0; eGrp = 0; eGrd = 0;
    for (int i = 0; i < ENTRIES; i++) begin
      low = (32'h1 << mShift[i]) - 1;
      if (!eHit && mValid[i] && mAsid[i] == sAsid && ((lkEa ^ mEpn[i]) & ~low) == 0) begin
        eHit = 1; eSlot = i; eGrp = mGrp[i]; eGrd = mGrd[i];
        ePa = (mRpn[i] & ~low) | (lkEa & low);
      end
    end
    compared++;
    if (lkHit !== eHit || lkSlot !== 5'(eSlot) || lkPa !== ePa ||
        lkGroup !== eGrp || lkGuarded !== eGrd) begin
      mismatched++;
      $display("FAIL %s ea=%h: hit/slot/pa/grp/grd actual %b/%0d/%h/%h/%b expected %b/%0d/%h/%h/%b",
               curReq, lkEa, lkHit, lkSlot, lkPa, lkGroup, lkGuarded,
               eHit, eSlot, ePa, eGrp, eGrd);
    end
  endtask

  task automatic step(input bit we, input logic [2:0] sel, input logic [31:0] d,
                      input logic [31:0] ea);
    wrEn = we; wrSel = sel; wrData = d; lkEa = ea;
    @(posedge clk);
    if (we) modelWrite(sel, d);
    #2;
    compareNow();
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    step(1'b1, sel, d, lkEa);
  endtask

  task automatic look(input logic [31:0] ea);
    step(1'b0, 3'd0, 32'h0, ea);
  endtask

  task automatic expectPa(input logic [31:0] exp, input string tag);
    compared++;
    if (lkHit !== 1'b1 || lkPa !== exp) begin
      mismatched++;
      $display("FAIL %s direct: hit/pa actual %b/%h expected 1/%h", tag, lkHit, lkPa, exp);
    end
  endtask

  // Load one entry: slot, reserve, epn word, segment word, rpn word.
  task automatic loadEntry(input int slot, input bit rsv, input logic [31:0] epnW,
                           input logic [31:0] segW, input logic [31:0] rpnW);
    wr(3'd0, (32'(rsv) << 27) | (32'(slot) << 8));
    wr(3'd1, epnW);
    wr(3'd2, segW);
    wr(3'd3, rpnW);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 0; wrEn = 0; wrSel = 0; wrData = 0; lkEa = 0;
    modelReset();
    repeat (3) @(posedge clk);
    #2 rstN = 1;

    curReq = "R1";
    look(32'h0000_0000);
    look(32'h1234_5678);

    // R1/R3: no control write yet, so the commit lands in slot 0
    curReq = "R3";
    wr(3'd4, 32'h5);
    wr(3'd1, 32'h1234_5000 | 32'h200 | 32'h5);
    wr(3'd2, (32'h3 << 5) | 32'h10 | 32'h1);
    wr(3'd3, 32'hABCD_E000);
    look(32'h1234_5678);
    expectPa(32'hABCD_E678, "R3");
    if (lkSlot !== 5'd0) begin
      mismatched++;
      $display("FAIL R1 reset index: actual %0d expected 0", lkSlot);
    end
    compared++;

    // R8 attributes
    curReq = "R8";
    look(32'h1234_5FFF);
    compared++;
    if (lkGroup !== 4'h3 || lkGuarded !== 1'b1) begin
      mismatched++;
      $display("FAIL R8: grp/grd actual %h/%b expected 3/1", lkGroup, lkGuarded);
    end

    // R5 space mismatch and return
    curReq = "R5";
    wr(3'd4, 32'h6);
    look(32'h1234_5678);
    wr(3'd4, 32'h5);
    look(32'h1234_5678);

    // R6/R7 sizes
    curReq = "R6";
    loadEntry(3, 0, 32'h4000_4205, 32'h1, 32'h5555_8008);  // 16K
    look(32'h4000_7ABC);
    expectPa(32'h5555_BABC, "R7");
    look(32'h4000_8000);
    loadEntry(4, 0, 32'h8008_0205, 32'h5, 32'h0110_0000);  // 512K
    look(32'h800F_1234);
    expectPa(32'h0117_1234, "R7");
    loadEntry(5, 0, 32'hC080_0205, 32'hD, 32'h0300_0000);  // 8M
    look(32'hC0FF_FFFF);
    expectPa(32'h037F_FFFF, "R7");
    look(32'hC100_0000);
    loadEntry(6, 0, 32'h7000_1205, 32'h9, 32'h2222_3000);  // code 10 -> 4K
    look(32'h7000_1FFF);
    look(32'h7000_2000);

    // R4 validity combinations
    curReq = "R4";
    loadEntry(7, 0, 32'h6000_0005, 32'h1, 32'h1111_1000);
    look(32'h6000_0010);
    loadEntry(8, 0, 32'h6100_0205, 32'h0, 32'h1111_2000);
    look(32'h6100_0010);

    // R9 overlap: slot 10 and slot 9 both cover the same page
    curReq = "R9";
    loadEntry(10, 0, 32'h5000_0205, 32'h1, 32'hAAAA_A000);
    look(32'h5000_0123);
    loadEntry(9, 0, 32'h5000_0205, 32'hC1, 32'hBBBB_B000);
    look(32'h5000_0123);
    compared++;
    if (lkSlot !== 5'd9) begin
      mismatched++;
      $display("FAIL R9: slot actual %0d expected 9", lkSlot);
    end

    // R10 reserve window
    curReq = "R10";
    loadEntry(30, 1, 32'h3000_0205, 32'h1, 32'h4444_4000);
    look(32'h3000_0000);
    loadEntry(27, 1, 32'h3100_0205, 32'h1, 32'h4444_5000);
    look(32'h3100_0000);
    loadEntry(30, 0, 32'h3000_0205, 32'h1, 32'h4444_4000);
    look(32'h3000_0000);
    loadEntry(30, 1, 32'h3000_0205, 32'h1, 32'h9999_9000);
    look(32'h3000_0000);

    // R2 staging writes and unused selects leave the table alone
    curReq = "R2";
    wr(3'd1, 32'h1234_5000);
    wr(3'd2, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'h0000_0000);
    look(32'h1234_5678);
    wr(3'd3, 32'h0);
    look(32'h1234_5678);

    // Mixed phase
    curReq = "R3";
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r, d;
      logic [2:0] s;
      r = nextRand();
      s = 3'(r[31:16] % 6);
      d = nextRand();
      if (s == 3'd1) d = {12'h001, d[19:10], 1'b1, d[8:4], 3'b000, d[0]};
      if (s == 3'd4) d = {31'h0, d[0]};
      if (r[3]) step(1'b1, s, d, {12'h001, nextRand() >> 12});
      else look({12'h001, nextRand() >> 12});
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule